// File: doc/BRIEF.md
# Adaptive Non-Overlap Gate Controller

This block controls one half-bridge channel from a three-level PWM command. The PWM level arrives as two digitized comparator flags. One says the level is above the upper threshold and the other says it is below the lower threshold. The block turns that level into two registered gate-enable outputs, one for the high-side switch and one for the low-side switch. The dead time between them is not a fixed delay. The block waits for digitized feedback flags to confirm that the outgoing gate has actually discharged, and only then turns on the incoming gate.

A level between the two thresholds is the tri-state command. If it lasts for a programmable hold-off, counted in clock cycles, both gates turn off. Enable and supply power-good both force the gates off while either one is low, and when both return the block starts again from idle. A feedback timeout guards each wait for a discharge flag. When it expires, the block holds both gates off and raises a fault flag, which the next valid PWM edge clears. Every flag input passes through a two-stage synchronizer, and one clock with a synchronous active-high reset runs the whole block.

Top module: `nonoverlap_gate_ctrl`

## Requirements
- R1: The PWM level decodes as high when the above-threshold flag is 1 and the below-threshold flag is 0. It decodes as low when below=1 and above=0. Both 0 and both 1 count as mid-window. A held high level leaves the high gate on with the low gate off, and a held low level gives the reverse.
- R2: If the synchronized level stays mid-window for HOLDOFF_CYC consecutive cycles, both gates go off. That happens on the (HOLDOFF_CYC+2)-th clock edge after the input change. A mid-window excursion shorter than HOLDOFF_CYC cycles leaves the gates unchanged.
- R3: On a change to high, the low gate turns off first. The high gate turns on only after the synchronized low-side gate-low feedback flag reads 1.
- R4: On a change to low, the high gate turns off first. The low gate turns on only after the synchronized high-side gate-to-switch-node-low flag or the switch-node-low flag reads 1, and either flag alone is enough.
- R5: The high and low gate outputs are never 1 in the same cycle.
- R6: While enable is 0, both gates are off. After enable returns to 1, the block restarts from idle and follows the current PWM level.
- R7: While power-good is 0, both gates are off, regardless of enable and PWM.
- R8: If a required feedback flag has not appeared FB_TIMEOUT cycles after a wait begins, the fault output goes to 1 and both gates stay off.
- R9: The fault output stays at 1 while the PWM level is held. It clears on the next change of the level into high or low, and the block then resumes normal switching.
- R10: After reset, both gates and the fault output are 0. The idle state is left only on a valid high or low level, never on a mid-window level.
- R11: A PWM change first affects the gate outputs on the third clock edge after it: two synchronizer stages plus the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Channel enable, asynchronous |
| pgood_i | input | 1 | Supply power-good flag, asynchronous |
| pwm_above_i | input | 1 | PWM level above upper threshold |
| pwm_below_i | input | 1 | PWM level below lower threshold |
| hs_vgs_low_i | input | 1 | High-side gate-to-switch-node voltage is low |
| sw_low_i | input | 1 | Switch-node voltage is low |
| ls_vg_low_i | input | 1 | Low-side gate voltage is low |
| hs_on_o | output | 1 | High-side gate enable, registered |
| ls_on_o | output | 1 | Low-side gate enable, registered |
| fault_o | output | 1 | Feedback timeout fault |

## Verification
A PWM, enable or power-good change first shows at the outputs on the third edge after it. A feedback flag that the bench models as the inverse of a gate output closes its loop three edges after that gate drops. An edge-to-edge command reversal therefore turns the incoming gate on at the sixth edge, or at the fourth edge when the feedback flag is already stable. The tri-state shutdown falls due on edge HOLDOFF_CYC+2, and the fault on edge FB_TIMEOUT+3. The bench changes inputs 1 ns after a rising edge, advances a counted number of edges, and samples 1 ns after the edge on which a result is due. It also checks the edge before, so an early change is caught as well as a late one.

// File: rtl/nonoverlap_gate_ctrl.sv
`timescale 1ns/1ps
module nonoverlap_gate_ctrl #(
  parameter int HOLDOFF_CYC = 35,
  parameter int FB_TIMEOUT  = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic pgood_i,
  input  logic pwm_above_i,
  input  logic pwm_below_i,
  input  logic hs_vgs_low_i,
  input  logic sw_low_i,
  input  logic ls_vg_low_i,
  output logic hs_on_o,
  output logic ls_on_o,
  output logic fault_o
);
  localparam int HW = $clog2(HOLDOFF_CYC + 1);
  localparam int TW = $clog2(FB_TIMEOUT + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_HS, S_LS, S_WAIT_HS_OFF, S_WAIT_LS_OFF, S_TRI, S_FAULT
  } state_t;
  typedef enum logic [1:0] {L_MID, L_HI, L_LO} lvl_t;

  logic [6:0] meta, sync;
  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      sync <= '0;
    end else begin
      meta <= {en_i, pgood_i, pwm_above_i, pwm_below_i, hs_vgs_low_i, sw_low_i, ls_vg_low_i};
      sync <= meta;
    end
  end

  logic en_s, pg_s, hi_s, lo_s, hsg_s, sw_s, ls_s;
  assign {en_s, pg_s, hi_s, lo_s, hsg_s, sw_s, ls_s} = sync;

  state_t state, nxt;
  lvl_t lvl, lvl_q;
  logic [HW-1:0] mid_cnt;
  logic [TW-1:0] wait_cnt;
  logic active, pwm_edge, hold_done, wait_done, hs_clear, in_wait;

  assign lvl       = (hi_s && !lo_s) ? L_HI : (lo_s && !hi_s) ? L_LO : L_MID;
  assign active    = en_s && pg_s;
  assign pwm_edge  = (lvl != L_MID) && (lvl != lvl_q);
  assign hold_done = (lvl == L_MID) && (mid_cnt == HW'(HOLDOFF_CYC - 1));
  assign wait_done = (wait_cnt == TW'(FB_TIMEOUT - 1));
  assign hs_clear  = hsg_s || sw_s;
  assign in_wait   = (state == S_WAIT_HS_OFF) || (state == S_WAIT_LS_OFF);

  always_comb begin
    nxt = state;
    if (!active) nxt = S_IDLE;
    else begin
      case (state)
        S_IDLE, S_TRI: begin
          if (lvl == L_HI) nxt = S_WAIT_LS_OFF;
          else if (lvl == L_LO) nxt = S_WAIT_HS_OFF;
        end
        S_HS: begin
          if (lvl == L_LO) nxt = S_WAIT_HS_OFF;
          else if (hold_done) nxt = S_TRI;
        end
        S_LS: begin
          if (lvl == L_HI) nxt = S_WAIT_LS_OFF;
          else if (hold_done) nxt = S_TRI;
        end
        S_WAIT_LS_OFF: begin
          if (lvl == L_LO) nxt = S_WAIT_HS_OFF;
          else if (hold_done) nxt = S_TRI;
          else if (lvl == L_HI && ls_s) nxt = S_HS;
          else if (wait_done) nxt = S_FAULT;
        end
        S_WAIT_HS_OFF: begin
          if (lvl == L_HI) nxt = S_WAIT_LS_OFF;
          else if (hold_done) nxt = S_TRI;
          else if (lvl == L_LO && hs_clear) nxt = S_LS;
          else if (wait_done) nxt = S_FAULT;
        end
        S_FAULT: begin
          if (pwm_edge) nxt = (lvl == L_HI) ? S_WAIT_LS_OFF : S_WAIT_HS_OFF;
        end
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      lvl_q    <= L_MID;
      mid_cnt  <= '0;
      wait_cnt <= '0;
      hs_on_o  <= 1'b0;
      ls_on_o  <= 1'b0;
      fault_o  <= 1'b0;
    end else begin
      state   <= nxt;
      lvl_q   <= lvl;
      hs_on_o <= (nxt == S_HS);
      ls_on_o <= (nxt == S_LS);
      fault_o <= (nxt == S_FAULT);
      if (lvl != L_MID || nxt != state) mid_cnt <= '0;
      else if (mid_cnt != HW'(HOLDOFF_CYC - 1)) mid_cnt <= mid_cnt + 1'b1;
      if (!in_wait || nxt != state) wait_cnt <= '0;
      else if (!wait_done) wait_cnt <= wait_cnt + 1'b1;
    end
  end

  // R5
  p_never_both_r5: assert property (@(posedge clk) disable iff (rst)
    !(hs_on_o && ls_on_o));
  p_hs_after_ls_low_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_on_o) |-> ($past(ls_s) && !$past(ls_on_o)));
  p_ls_after_hs_low_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_on_o) |-> (($past(hsg_s) || $past(sw_s)) && !$past(hs_on_o)));
  p_inactive_off_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(active) |-> (!hs_on_o && !ls_on_o));
  p_fault_gates_off_r8: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> (!hs_on_o && !ls_on_o));
  p_fault_clear_edge_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(fault_o) |-> (!$past(active) || ($past(lvl) != L_MID && $past(lvl) != $past(lvl_q))));
endmodule

// File: tb/test_nonoverlap_gate_ctrl.sv
`timescale 1ns/1ps
module test_nonoverlap_gate_ctrl;
  localparam int HOLD = 35;
  localparam int TOUT = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b1, pg = 1'b1, above = 1'b0, below = 1'b0;
  logic auto_hs = 1'b1, force_hs = 1'b0, force_sw = 1'b0;
  logic auto_ls = 1'b1, force_ls = 1'b0;
  logic hs_on, ls_on, fault;
  logic hs_fb, ls_fb;
  int vectors = 0, miscompares = 0;

  always #2.5 clk = ~clk;

  assign hs_fb = auto_hs ? ~hs_on : force_hs;
  assign ls_fb = auto_ls ? ~ls_on : force_ls;

  nonoverlap_gate_ctrl #(.HOLDOFF_CYC(HOLD), .FB_TIMEOUT(TOUT)) i_nonoverlap_gate_ctrl (
    .clk(clk), .rst(rst), .en_i(en), .pgood_i(pg),
    .pwm_above_i(above), .pwm_below_i(below),
    .hs_vgs_low_i(hs_fb), .sw_low_i(force_sw), .ls_vg_low_i(ls_fb),
    .hs_on_o(hs_on), .ls_on_o(ls_on), .fault_o(fault));

  task automatic chk(input string tag, input logic [2:0] exp);
    vectors++;
    if ({hs_on, ls_on, fault} !== exp) begin
      miscompares++;
      $display("FAIL %s: got hs/ls/fault=%b expected %b", tag, {hs_on, ls_on, fault}, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      vectors++;
      if (hs_on && ls_on) begin
        miscompares++;
        $display("FAIL R5 both gates on: got 11 expected not 11");
      end
    end
  endtask

  task automatic set_pwm(input logic a, input logic b);
    above = a; below = b;
  endtask

  task automatic t_reset;
    rst = 1'b1; set_pwm(0, 0);
    tick(4);
    chk("R10 reset state", 3'b000);
    rst = 1'b0;
    tick(12);
    chk("R10 idle holds on mid level", 3'b000);
  endtask

  task automatic t_rise_from_idle;
    set_pwm(1, 0);
    tick(2); chk("R11 no change before third edge", 3'b000);
    tick(1); chk("R3 wait state after idle", 3'b000);
    tick(1); chk("R1 high level turns high gate on", 3'b100);
    tick(5); chk("R1 high level held", 3'b100);
  endtask

  task automatic t_fall;
    set_pwm(0, 1);
    tick(2); chk("R11 high gate held for two edges", 3'b100);
    tick(1); chk("R4 high gate released first", 3'b000);
    tick(2); chk("R4 low gate waits for feedback", 3'b000);
    tick(1); chk("R4 low gate on after feedback", 3'b010);
    tick(5); chk("R1 low level held", 3'b010);
  endtask

  task automatic t_rise;
    set_pwm(1, 0);
    tick(2); chk("R11 low gate held for two edges", 3'b010);
    tick(1); chk("R3 low gate released first", 3'b000);
    tick(2); chk("R3 high gate waits for feedback", 3'b000);
    tick(1); chk("R3 high gate on after low gate low", 3'b100);
  endtask

  task automatic t_switch_node_only;
    auto_hs = 1'b0; force_hs = 1'b0; force_sw = 1'b1;
    set_pwm(0, 1);
    tick(3); chk("R4 sw path high gate off", 3'b000);
    tick(1); chk("R4 switch-node-low alone enables low gate", 3'b010);
    force_sw = 1'b0; auto_hs = 1'b1;
    tick(4);
  endtask

  task automatic t_holdoff;
    set_pwm(1, 1);
    tick(HOLD + 1); chk("R2 low gate kept before hold-off", 3'b010);
    tick(1); chk("R2 both off after hold-off (both flags set)", 3'b000);
    tick(10); chk("R2 tri-state held", 3'b000);
    set_pwm(1, 0);
    tick(4); chk("R1 leaves tri-state on high level", 3'b100);
    set_pwm(0, 0);
    tick(HOLD - 1);
    set_pwm(1, 0);
    for (int i = 0; i < HOLD + 6; i++) begin
      tick(1); chk("R2 short mid excursion ignored", 3'b100);
    end
  endtask

  task automatic t_timeout;
    auto_hs = 1'b0; force_hs = 1'b0; force_sw = 1'b0;
    set_pwm(0, 1);
    tick(3); chk("R8 waiting high gate off", 3'b000);
    tick(TOUT - 1); chk("R8 no fault before timeout", 3'b000);
    tick(1); chk("R8 fault at timeout", 3'b001);
    auto_hs = 1'b1;
    tick(20); chk("R9 held level does not clear fault", 3'b001);
    set_pwm(1, 0);
    tick(2); chk("R9 fault before edge reaches logic", 3'b001);
    tick(1); chk("R9 fault cleared by edge", 3'b000);
    tick(1); chk("R9 switching resumes", 3'b100);
  endtask

  task automatic t_pgood;
    pg = 1'b0;
    tick(2); chk("R7 gate held during sync", 3'b100);
    tick(1); chk("R7 power-good low forces off", 3'b000);
    tick(10); chk("R7 off despite high level", 3'b000);
    set_pwm(0, 0);
    tick(4);
    pg = 1'b1;
    tick(20); chk("R10 restart idle ignores mid level", 3'b000);
    set_pwm(0, 1);
    tick(3); chk("R10 leaves idle on low level", 3'b000);
    tick(1); chk("R10 low gate on from idle", 3'b010);
  endtask

  task automatic t_enable;
    en = 1'b0;
    tick(2); chk("R6 gate held during sync", 3'b010);
    tick(1); chk("R6 enable low forces off", 3'b000);
    tick(10); chk("R6 off while disabled", 3'b000);
    en = 1'b1;
    tick(3); chk("R6 restart through wait", 3'b000);
    tick(1); chk("R6 follows low level after enable", 3'b010);
  endtask

  initial begin
    #1_000_000;
    miscompares++;
    $display("FAIL watchdog: run did not finish");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_rise_from_idle();
    t_fall();
    t_rise();
    t_switch_node_only();
    t_holdoff();
    t_timeout();
    t_pgood();
    t_enable();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule